// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block sits on the receive path of an Ethernet MAC. It watches the first six bytes of every incoming frame, which form the destination address. From those bytes it decides whether the frame is for this station. The bytes arrive one per valid cycle. A start-of-frame flag marks the first byte.

Four rules settle the verdict:
- Promiscuous mode accepts everything.
- The all-ones broadcast address is always accepted.
- A group address is judged by one bit of a 512-entry hash table.
- An individual address must equal the programmed station address.

The hash index is taken from a CRC-32 that the block accumulates over the address bytes while they stream in. The verdict is therefore ready one cycle after the sixth byte, with no extra pass over the address.

Configuration uses plain write strobes:
- A hash control word sets or clears one table entry per write.
- Two station-address words load the station address.
- A single bit selects promiscuous mode.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset the block holds these values: no decision strobe, every hash entry cleared, promiscuous mode off and a station address of zero. Right after reset, a group address other than broadcast is therefore rejected, and so is any non-zero individual address.
- R2: `dec_valid` pulses for exactly one cycle. That cycle is the one after the clock edge that consumes the sixth valid byte of a frame. Idle cycles between bytes only delay it. `dec_accept` is low whenever `dec_valid` is low. Bytes after the sixth produce no further strobe, and so do bytes that arrive with no preceding start-of-frame.
- R3: The hash index comes from a reflected CRC-32: polynomial 0xEDB88320, shifted least significant bit first, initial value 0xFFFFFFFF, no final inversion. The CRC runs over the six address bytes in arrival order. The result is bit-reversed and its bits [31:23] form the index. Equivalently, index bit i equals CRC bit 8-i.
- R4: A hash write takes bits [8:0] of `hash_wr_word` as the entry index and bit 9 as the new value. A 1 sets the entry and a 0 clears it. No other entry changes.
- R5: A group address (bit 0 of the first byte set) that is not broadcast is accepted exactly when its hash entry is set. An individual address never consults the table.
- R6: An individual address is accepted only when all 48 bits equal the station address. `sta_lo_data` carries bytes 0..3, with byte 0 (the first byte on the wire) in bits [7:0]. `sta_hi_data` carries bytes 4..5, with byte 4 in bits [7:0].
- R7: The address FF:FF:FF:FF:FF:FF is accepted whatever the contents of the hash table.
- R8: While promiscuous mode is on, every frame is accepted. A promiscuous-mode write takes effect for decisions made after its clock edge.
- R9: A hash write may land in the same cycle as the sixth byte of a frame whose address maps to that index. In that case the decision uses the entry value from before the write.
- R10: A start-of-frame flag in the middle of an address discards the partial address and restarts the CRC. The decision then reflects only the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_byte | input | 8 | Receive byte |
| hash_wr_en | input | 1 | Write strobe for the hash control word |
| hash_wr_word | input | 10 | Bits [8:0] entry index, bit 9 value |
| sta_lo_wr_en | input | 1 | Write strobe for station bytes 0..3 |
| sta_lo_data | input | 32 | Station bytes 0..3, byte 0 in [7:0] |
| sta_hi_wr_en | input | 1 | Write strobe for station bytes 4..5 |
| sta_hi_data | input | 16 | Station bytes 4..5, byte 4 in [7:0] |
| promisc_wr_en | input | 1 | Write strobe for promiscuous mode |
| promisc_data | input | 1 | New promiscuous mode value |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted, qualified by dec_valid |

## Verification
A table lookup and a table update can fall in the same cycle. The lookup happens when the sixth address byte arrives, and the update is a hash control write.

The bench forces this collision by driving the hash write in the same cycle as the final byte. The write targets the entry that the bench's own CRC model predicts for that address. The bench tries it in both directions:
- A set landing on a cleared entry must still reject.
- A clear landing on a set entry must still accept.

A repeat of each frame then confirms that the write did take effect for the next frame.

// File: rtl/maf_pkg.sv
package maf_pkg;

    localparam int unsigned MAC_BYTES = 6;
    localparam int unsigned MAC_W     = 8 * MAC_BYTES;
    localparam logic [31:0] CRC_POLY  = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    // One byte of a reflected CRC-32, least significant bit first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int j = 0; j < 8; j++) begin
            fb = r[0] ^ b[j];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    typedef struct packed {
        logic valid;
        logic accept;
    } verdict_t;

endpackage

// File: rtl/maf_addr_accum.sv
module maf_addr_accum
    import maf_pkg::*;
#(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic [7:0]       in_byte,
    output logic             done_o,
    output logic [MAC_W-1:0] addr_o,
    output logic [IDX_W-1:0] idx_o
);
    localparam int unsigned CNT_W = $clog2(MAC_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAC_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAC_BYTES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [31:0]      crc;
        logic [MAC_W-1:0] addr;
    } acc_t;

    acc_t acc_d, acc_q, base;

    always_comb begin
        base = acc_q;
        if (in_valid && in_sof) begin
            base.cnt  = '0;
            base.crc  = CRC_SEED;
            base.addr = '0;
        end
        acc_d  = base;
        done_o = 1'b0;
        if (in_valid && (base.cnt < CNT_FULL)) begin
            acc_d.crc = crc_byte(base.crc, in_byte);
            for (int k = 0; k < MAC_BYTES; k++) begin
                if (base.cnt == CNT_W'(k)) acc_d.addr[8*k +: 8] = in_byte;
            end
            acc_d.cnt = base.cnt + CNT_W'(1);
            done_o    = (base.cnt == CNT_LAST);
        end
        if (!in_valid) acc_d = acc_q;
        addr_o = acc_d.addr;
        // Top IDX_W bits of the bit-reversed CRC.
        for (int i = 0; i < IDX_W; i++) begin
            idx_o[i] = acc_d.crc[IDX_W-1-i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q.cnt  <= CNT_FULL;
            acc_q.crc  <= CRC_SEED;
            acc_q.addr <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

endmodule

// File: rtl/maf_hash_table.sv
module maf_hash_table #(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_hit
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] tbl_d, tbl_q;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) tbl_d[wr_idx] = wr_val;
        // Lookup sees the value held before any write in this cycle.
        rd_hit = tbl_q[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

endmodule

// File: rtl/maf_station_regs.sv
module maf_station_regs
    import maf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lo_we,
    input  logic [31:0]      lo_data,
    input  logic             hi_we,
    input  logic [15:0]      hi_data,
    input  logic             prom_we,
    input  logic             prom_data,
    output logic [MAC_W-1:0] station_o,
    output logic             promisc_o
);
    typedef struct packed {
        logic [15:0] hi;
        logic [31:0] lo;
        logic        prom;
    } sta_t;

    sta_t sta_d, sta_q;

    always_comb begin
        sta_d = sta_q;
        if (lo_we)   sta_d.lo   = lo_data;
        if (hi_we)   sta_d.hi   = hi_data;
        if (prom_we) sta_d.prom = prom_data;
        station_o = {sta_q.hi, sta_q.lo};
        promisc_o = sta_q.prom;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sta_q <= '0;
        else        sta_q <= sta_d;
    end

endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
    import maf_pkg::*;
#(
    parameter int unsigned HASH_IDX_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic                  rx_sof,
    input  logic [7:0]            rx_byte,
    input  logic                  hash_wr_en,
    input  logic [HASH_IDX_W:0]   hash_wr_word,
    input  logic                  sta_lo_wr_en,
    input  logic [31:0]           sta_lo_data,
    input  logic                  sta_hi_wr_en,
    input  logic [15:0]           sta_hi_data,
    input  logic                  promisc_wr_en,
    input  logic                  promisc_data,
    output logic                  dec_valid,
    output logic                  dec_accept
);
    logic                  addr_done;
    logic [MAC_W-1:0]      addr_cur;
    logic [HASH_IDX_W-1:0] hash_idx;
    logic                  hash_hit;
    logic [MAC_W-1:0]      station;
    logic                  promisc;

    maf_addr_accum #(.IDX_W(HASH_IDX_W)) u_accum (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(rx_valid),
        .in_sof  (rx_sof),
        .in_byte (rx_byte),
        .done_o  (addr_done),
        .addr_o  (addr_cur),
        .idx_o   (hash_idx)
    );

    maf_hash_table #(.IDX_W(HASH_IDX_W)) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (hash_wr_en),
        .wr_idx(hash_wr_word[HASH_IDX_W-1:0]),
        .wr_val(hash_wr_word[HASH_IDX_W]),
        .rd_idx(hash_idx),
        .rd_hit(hash_hit)
    );

    maf_station_regs u_sta (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_we    (sta_lo_wr_en),
        .lo_data  (sta_lo_data),
        .hi_we    (sta_hi_wr_en),
        .hi_data  (sta_hi_data),
        .prom_we  (promisc_wr_en),
        .prom_data(promisc_data),
        .station_o(station),
        .promisc_o(promisc)
    );

    verdict_t vd_d, vd_q;
    logic is_bcast, is_group, sta_match;

    always_comb begin
        is_bcast  = &addr_cur;
        is_group  = addr_cur[0];
        sta_match = (addr_cur == station);
        vd_d.valid  = addr_done;
        vd_d.accept = addr_done &&
                      (promisc || is_bcast || (is_group ? hash_hit : sta_match));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '0;
        else        vd_q <= vd_d;
    end

    assign dec_valid  = vd_q.valid;
    assign dec_accept = vd_q.accept;

endmodule

// File: rtl/maf_checker.sv
module maf_checker (
    input logic clk,
    input logic rst_n,
    input logic rx_valid,
    input logic promisc_wr_en,
    input logic promisc_data,
    input logic dec_valid,
    input logic dec_accept
);
    logic prom_shadow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             prom_shadow_q <= 1'b0;
        else if (promisc_wr_en) prom_shadow_q <= promisc_data;
    end

    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);

    p_strobe_after_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> $past(rx_valid));

    p_accept_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);

    p_promisc_accepts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && $past(prom_shadow_q)) |-> dec_accept);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !dec_valid);

endmodule

bind mcast_addr_filter maf_checker u_maf_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .rx_valid     (rx_valid),
    .promisc_wr_en(promisc_wr_en),
    .promisc_data (promisc_data),
    .dec_valid    (dec_valid),
    .dec_accept   (dec_accept)
);

// File: tb/test_mcast_addr_filter.sv
module test_mcast_addr_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        hash_wr_en = 1'b0;
    logic [9:0]  hash_wr_word = '0;
    logic        sta_lo_wr_en = 1'b0, sta_hi_wr_en = 1'b0;
    logic [31:0] sta_lo_data = '0;
    logic [15:0] sta_hi_data = '0;
    logic        promisc_wr_en = 1'b0, promisc_data = 1'b0;
    logic        dec_valid, dec_accept;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Bench model of programmable state.
    logic [511:0] m_tbl = '0;
    logic [47:0]  m_sta = '0;
    logic         m_prom = 1'b0;

    always #10 clk = ~clk;

    mcast_addr_filter i_mcast_addr_filter (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_byte(rx_byte),
        .hash_wr_en(hash_wr_en), .hash_wr_word(hash_wr_word),
        .sta_lo_wr_en(sta_lo_wr_en), .sta_lo_data(sta_lo_data),
        .sta_hi_wr_en(sta_hi_wr_en), .sta_hi_data(sta_hi_data),
        .promisc_wr_en(promisc_wr_en), .promisc_data(promisc_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reflected CRC-32 and index per R3.
    function automatic logic [8:0] exp_idx(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [31:0] rv;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                bit fb = c[0] ^ a[8*k+j];
                c = c >> 1;
                if (fb) c = c ^ 32'hEDB8_8320;
            end
        end
        for (int j = 0; j < 32; j++) rv[31-j] = c[j];
        return rv[31:23];
    endfunction

    function automatic bit exp_acc(input logic [47:0] a);
        if (m_prom) return 1'b1;
        if (a == 48'hFFFF_FFFF_FFFF) return 1'b1;
        if (a[0]) return m_tbl[exp_idx(a)];
        return a == m_sta;
    endfunction

    task automatic hash_write(input int idx, input bit val);
        @(negedge clk);
        hash_wr_en = 1'b1; hash_wr_word = {val, 9'(idx)};
        @(negedge clk);
        hash_wr_en = 1'b0;
        m_tbl[idx] = val;
    endtask

    task automatic set_station(input logic [47:0] a);
        @(negedge clk);
        sta_lo_wr_en = 1'b1; sta_lo_data = a[31:0];
        sta_hi_wr_en = 1'b1; sta_hi_data = a[47:32];
        @(negedge clk);
        sta_lo_wr_en = 1'b0; sta_hi_wr_en = 1'b0;
        m_sta = a;
    endtask

    task automatic set_prom(input bit v);
        @(negedge clk);
        promisc_wr_en = 1'b1; promisc_data = v;
        @(negedge clk);
        promisc_wr_en = 1'b0;
        m_prom = v;
    endtask

    // Sends six address bytes; optional hash write alongside the last byte.
    task automatic send_addr(input logic [47:0] a, input int gap, input bit hw,
                             input logic [9:0] hword, output bit v, output bit acc);
        for (int k = 0; k < 6; k++) begin
            if (k > 0) begin
                for (int g = 0; g < gap; g++) begin
                    @(negedge clk);
                    rx_valid = 1'b0; rx_sof = 1'b0;
                end
            end
            @(negedge clk);
            if (k > 0) check(dec_valid == 1'b0, "R2 early strobe", dec_valid, 0);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = a[8*k +: 8];
            if (k == 5 && hw) begin
                hash_wr_en = 1'b1; hash_wr_word = hword;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; hash_wr_en = 1'b0;
        v = dec_valid; acc = dec_accept;
        if (hw) m_tbl[hword[8:0]] = hword[9];
    endtask

    task automatic frame_check(input logic [47:0] a, input string req);
        bit v, acc, e;
        e = exp_acc(a);
        send_addr(a, 0, 1'b0, '0, v, acc);
        check(v == 1'b1, req, v, 1);
        check(acc == e, req, acc, e);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            report();
        end
    end

    initial begin
        bit v, acc;
        logic [47:0] a;
        repeat (3) @(negedge clk);
        check(dec_valid == 1'b0, "R1 reset strobe", dec_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dec_valid == 1'b0, "R1 idle after reset", dec_valid, 0);

        // R1: cleared table and zero station.
        send_addr(48'h01_00_00_5E_00_01, 0, 1'b0, '0, v, acc);
        check(v && !acc, "R1 multicast rejected after reset", acc, 0);
        send_addr(48'h06_05_04_03_02_02, 0, 1'b0, '0, v, acc);
        check(v && !acc, "R1 unicast rejected after reset", acc, 0);

        // R2: bytes without start-of-frame are ignored.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check(dec_valid == 1'b0, "R2 no strobe without sof", dec_valid, 0);
        @(negedge clk);
        check(dec_valid == 1'b0, "R2 no strobe without sof", dec_valid, 0);

        // R6: station match with packing, each single-bit mismatch.
        set_station(48'h55_44_33_22_11_02);
        frame_check(48'h55_44_33_22_11_02, "R6 station match");
        for (int b = 1; b < 48; b++) begin
            a = 48'h55_44_33_22_11_02 ^ (48'h1 << b);
            frame_check(a, "R6 single-bit mismatch");
        end

        // R7: broadcast with empty table.
        frame_check(48'hFFFF_FFFF_FFFF, "R7 broadcast");

        // R2: gaps delay the strobe; one cycle wide; trailing bytes ignored.
        send_addr(48'hFFFF_FFFF_FFFF, 3, 1'b0, '0, v, acc);
        check(v && acc, "R2 strobe after gapped frame", v, 1);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(dec_valid == 1'b0, "R2 strobe one cycle / trailing bytes", dec_valid, 0);
            rx_valid = 1'b1; rx_sof = 1'b0; rx_byte = 8'hFF;
        end
        @(negedge clk);
        rx_valid = 1'b0;
        check(dec_valid == 1'b0, "R2 trailing bytes ignored", dec_valid, 0);

        // R3 R4 R5: sweep all entries with a pattern, probe many group addresses.
        for (int i = 0; i < 512; i++) hash_write(i, ((i * 7) % 5) < 2);
        for (int n = 0; n < 300; n++) begin
            a = {8'(n * 29), 8'(n ^ 8'h5A), 8'(n >> 3), 8'(n * 3), 8'(n >> 5), {7'(n), 1'b1}};
            frame_check(a, "R3 R5 hash lookup");
        end
        // R5: table full, unicast still needs station match.
        for (int i = 0; i < 512; i++) hash_write(i, 1'b1);
        frame_check(48'h01_02_03_04_05_06, "R5 unicast ignores table");
        frame_check(48'h01_02_03_04_05_07, "R5 all-multicast accept");
        // R4: single clear affects only its index.
        a = 48'h10_20_30_5E_00_01;
        hash_write(exp_idx(a), 1'b0);
        frame_check(a, "R4 cleared entry rejects");
        frame_check(48'hFFFF_FFFF_FFFF, "R7 broadcast with cleared entry");
        hash_write((exp_idx(a) + 1) % 512, 1'b1);
        frame_check(a, "R4 neighbour write leaves entry");
        for (int i = 0; i < 512; i++) hash_write(i, 1'b0);
        frame_check(48'h10_20_30_5E_00_03, "R4 all cleared");

        // R8: promiscuous accepts all.
        set_prom(1'b1);
        frame_check(48'h10_20_30_5E_00_03, "R8 promisc multicast");
        frame_check(48'hAB_CD_EF_01_23_44, "R8 promisc unicast");
        set_prom(1'b0);
        frame_check(48'hAB_CD_EF_01_23_44, "R8 promisc off");

        // R9: same-cycle write and lookup see the old value.
        a = 48'h77_66_55_5E_00_01;
        send_addr(a, 0, 1'b1, {1'b1, exp_idx(a)}, v, acc);
        check(v && !acc, "R9 set in same cycle uses old", acc, 0);
        frame_check(a, "R9 set visible next frame");
        send_addr(a, 0, 1'b1, {1'b0, exp_idx(a)}, v, acc);
        check(v && acc, "R9 clear in same cycle uses old", acc, 1);
        frame_check(a, "R9 clear visible next frame");

        // R10: sof mid-address restarts.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = 8'hFF;
        end
        frame_check(48'h55_44_33_22_11_02, "R10 restart to station");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (k == 0); rx_byte = 8'h02 + 8'(k);
        end
        frame_check(48'hFFFF_FFFF_FFFF, "R10 restart to broadcast");

        finished = 1;
        report();
    end

endmodule